// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds the error-logging registers of a machine-check unit. Three global registers sit beside a set of error banks: a capability word, a global control word and a global status word. Each bank has its own control, status, address and misc word. An error source presents one event at a time on a single-cycle injection strobe. The event carries a bank index, a bank status word, a global status word, an address and a misc word. The block checks the event against the capability, the control masks and the in-progress state. It then logs the event, marks an overflow, drops it, or asks for a system reset. An accepted uncorrected error raises a machine-check interrupt pulse.

A power-up initialisation strobe carries the processor signature fields and the two machine-check feature flags. A qualifying signature enables the bank logic and opens every control mask. The signature also decides whether the core can take part in a broadcast of machine-check events. A simple register port gives software-style access. Reads are combinational. Writes take effect on the next clock edge and can open or close control masks and clear status words.

Top module: `mca_bank_logger`

## Requirements
- R1: An injection is dropped with no register change and no pulse when the bank index is not below the bank count (capability bits [7:0]), or when the valid bit (status bit W-1) is clear.
- R2: An uncorrected error (status bit W-3 set) is dropped when capability bit 8 (global control present) is set and the global control word is not all ones.
- R3: An uncorrected error is dropped when the addressed bank's control word is not all ones.
- R4: An uncorrected error that passes R2 and R3 produces a one-cycle reset-request pulse and is not logged when the in-progress bit (global status bit 2) is set or the machine-check enable input is low.
- R5: An accepted uncorrected error writes the global status, bank address, bank misc and bank status, and raises a one-cycle interrupt pulse. The stored status gets the overflow bit (bit W-2) set if the bank already held a valid entry.
- R6: A corrected error overwrites status, address and misc when the bank holds no valid entry or holds a corrected entry, setting overflow if an entry was valid. If the bank holds a valid uncorrected entry, only that entry's overflow bit is set.
- R7: Reset clears every register and output. An init strobe with family >= 6 and both feature flags set loads capability = (1<<8) | NBANK and sets the global control and all bank controls to all ones; otherwise the registers are unchanged.
- R8: The broadcast flag, captured at each init strobe, is high when family == 6 and model >= 14, or when family > 6. The model is ext_model*16 + base_model.
- R9: A corrected error never pulses the interrupt or the reset request. Every pulse lasts one cycle and appears in the cycle after the strobe edge. The two pulses are never high together.
- R10: Register select codes are 0 capability, 1 global control, 2 global status, 3 bank control, 4 bank status, 5 bank address and 6 bank misc. Writes to codes 1 to 4 take effect, and a write to the capability is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_go | input | 1 | Power-up initialisation strobe |
| sig_family | input | 4 | Processor family field |
| sig_model | input | 4 | Base model field |
| sig_ext_model | input | 4 | Extended model field |
| feat_mce | input | 1 | Machine-check exception feature flag |
| feat_mca | input | 1 | Machine-check architecture feature flag |
| mce_en | input | 1 | Machine-check enable from the control register |
| inj_vld | input | 1 | Injection strobe, one cycle |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | W | Bank status word of the event |
| inj_gstat | input | W | Global status word of the event |
| inj_addr | input | W | Address word of the event |
| inj_misc | input | W | Misc word of the event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for write (R10 codes) |
| wr_bank | input | BW | Bank for write |
| wr_data | input | W | Write data |
| rd_sel | input | 3 | Register select for read |
| rd_bank | input | BW | Bank for read |
| rd_data | output | W | Read data, combinational |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |
| bcast_ok | output | 1 | Broadcast capability flag |

## Verification
The interrupt and reset-request pulses come from registers, so they are due one cycle after the edge that samples the strobe. They must be gone again one cycle later. The scoreboard monitor sees the strobe at the sampling edge, waits a short delay into that next cycle, compares both pulses with the queued expectation, and then checks that both are low one cycle on. Register effects of an injection, a write or an init are read through the combinational read port at the following falling edge. Injections are spaced several cycles apart so that each expectation belongs to exactly one strobe.

// File: rtl/mca_pkg.sv
package mca_pkg;

    localparam int CAP_CTLP_BIT = 8;
    localparam int GST_INPROG_BIT = 2;
    localparam int MIN_FAMILY = 6;
    localparam int BCAST_MODEL = 14;

    typedef enum logic [2:0] {
        SEL_CAP   = 3'd0,
        SEL_GCTL  = 3'd1,
        SEL_GSTAT = 3'd2,
        SEL_BCTL  = 3'd3,
        SEL_BSTAT = 3'd4,
        SEL_BADDR = 3'd5,
        SEL_BMISC = 3'd6
    } reg_sel_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DROP,
        ACT_RESET,
        ACT_LOG_UC,
        ACT_LOG_CE,
        ACT_MARK_OVER
    } inj_act_e;

    function automatic logic [7:0] full_model(input logic [3:0] ext, input logic [3:0] base);
        return {ext, base};
    endfunction

endpackage

// File: rtl/mca_sig_decode.sv
module mca_sig_decode
    import mca_pkg::*;
(
    input  logic [3:0] sig_family,
    input  logic [3:0] sig_model,
    input  logic [3:0] sig_ext_model,
    input  logic       feat_mce,
    input  logic       feat_mca,
    output logic       init_ok,
    output logic       bcast_c
);
    logic [7:0] model;

    always_comb begin
        model   = full_model(sig_ext_model, sig_model);
        init_ok = (32'(sig_family) >= MIN_FAMILY) && feat_mce && feat_mca;
        bcast_c = ((32'(sig_family) == MIN_FAMILY) && (32'(model) >= BCAST_MODEL))
                  || (32'(sig_family) > MIN_FAMILY);
    end
endmodule

// File: rtl/mca_inject_ctrl.sv
module mca_inject_ctrl
    import mca_pkg::*;
#(
    parameter int W     = 64,
    parameter int NBANK = 4
) (
    input  logic         inj_vld,
    input  logic [7:0]   inj_bank,
    input  logic [W-1:0] inj_status,
    input  logic [7:0]   cap_nbank,
    input  logic         cap_ctlp,
    input  logic [W-1:0] gctl,
    input  logic         inprog,
    input  logic         mce_en,
    input  logic [W-1:0] bank_ctl,
    input  logic [W-1:0] bank_stat,
    output inj_act_e     act,
    output logic [W-1:0] new_status
);
    localparam logic [W-1:0] ONE_M  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] VAL_M  = ONE_M << (W-1);
    localparam logic [W-1:0] OVER_M = ONE_M << (W-2);
    localparam int UC_B = W - 3;

    logic in_range;
    logic old_val;
    logic [W-1:0] over_if_old;

    always_comb begin
        in_range    = (inj_bank < cap_nbank) && (32'(inj_bank) < NBANK);
        old_val     = bank_stat[W-1];
        over_if_old = old_val ? OVER_M : '0;
        act         = ACT_NONE;
        new_status  = bank_stat;
        if (inj_vld) begin
            if (!in_range || ((inj_status & VAL_M) == '0)) begin
                act = ACT_DROP;
            end else if (inj_status[UC_B]) begin
                if (cap_ctlp && (gctl != '1)) begin
                    act = ACT_DROP;
                end else if (bank_ctl != '1) begin
                    act = ACT_DROP;
                end else if (inprog || !mce_en) begin
                    act = ACT_RESET;
                end else begin
                    act        = ACT_LOG_UC;
                    new_status = inj_status | over_if_old;
                end
            end else if (!old_val || !bank_stat[UC_B]) begin
                act        = ACT_LOG_CE;
                new_status = inj_status | over_if_old;
            end else begin
                act        = ACT_MARK_OVER;
                new_status = bank_stat | OVER_M;
            end
        end
    end
endmodule

// File: rtl/mca_bank_regs.sv
module mca_bank_regs #(
    parameter int W     = 64,
    parameter int NBANK = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_set,
    input  logic [BW-1:0] bank_idx,
    input  logic          ctl_we,
    input  logic [W-1:0]  ctl_d,
    input  logic          stat_we,
    input  logic [W-1:0]  stat_d,
    input  logic          log_we,
    input  logic [W-1:0]  addr_d,
    input  logic [W-1:0]  misc_d,
    output logic [W-1:0]  ctl_q  [NBANK],
    output logic [W-1:0]  stat_q [NBANK],
    output logic [W-1:0]  addr_q [NBANK],
    output logic [W-1:0]  misc_q [NBANK]
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (32'(bank_idx) == b);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[b]  <= '0;
                stat_q[b] <= '0;
                addr_q[b] <= '0;
                misc_q[b] <= '0;
            end else begin
                if (init_set) begin
                    ctl_q[b] <= '1;
                end else if (ctl_we && hit) begin
                    ctl_q[b] <= ctl_d;
                end
                if (stat_we && hit) begin
                    stat_q[b] <= stat_d;
                end
                if (log_we && hit) begin
                    addr_q[b] <= addr_d;
                    misc_q[b] <= misc_d;
                end
            end
        end
    end
endmodule

// File: rtl/mca_bank_logger.sv
module mca_bank_logger
    import mca_pkg::*;
#(
    parameter int W     = 64,
    parameter int NBANK = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_go,
    input  logic [3:0]    sig_family,
    input  logic [3:0]    sig_model,
    input  logic [3:0]    sig_ext_model,
    input  logic          feat_mce,
    input  logic          feat_mca,
    input  logic          mce_en,
    input  logic          inj_vld,
    input  logic [7:0]    inj_bank,
    input  logic [W-1:0]  inj_status,
    input  logic [W-1:0]  inj_gstat,
    input  logic [W-1:0]  inj_addr,
    input  logic [W-1:0]  inj_misc,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [BW-1:0] wr_bank,
    input  logic [W-1:0]  wr_data,
    input  logic [2:0]    rd_sel,
    input  logic [BW-1:0] rd_bank,
    output logic [W-1:0]  rd_data,
    output logic          mce_irq,
    output logic          reset_req,
    output logic          bcast_ok
);
    localparam logic [W-1:0] CAP_INIT = (W'(1) << CAP_CTLP_BIT) | W'(NBANK);

    logic [W-1:0] cap_q, gctl_q, gstat_q;
    logic         irq_q, rreq_q, bcast_q;
    logic [W-1:0] bctl_q [NBANK];
    logic [W-1:0] bstat_q[NBANK];
    logic [W-1:0] baddr_q[NBANK];
    logic [W-1:0] bmisc_q[NBANK];

    logic         init_ok, bcast_c;
    logic         inj_live;
    inj_act_e     act;
    logic [W-1:0] new_status;
    logic [BW-1:0] inj_idx, bank_idx;
    reg_sel_e     wsel, rsel;
    logic         ctl_we, stat_we, log_we;
    logic [W-1:0] stat_d;

    mca_sig_decode u_sig (
        .sig_family   (sig_family),
        .sig_model    (sig_model),
        .sig_ext_model(sig_ext_model),
        .feat_mce     (feat_mce),
        .feat_mca     (feat_mca),
        .init_ok      (init_ok),
        .bcast_c      (bcast_c)
    );

    assign inj_idx  = inj_bank[BW-1:0];
    assign inj_live = inj_vld && !init_go && !wr_en;

    mca_inject_ctrl #(.W(W), .NBANK(NBANK)) u_ctrl (
        .inj_vld   (inj_live),
        .inj_bank  (inj_bank),
        .inj_status(inj_status),
        .cap_nbank (cap_q[7:0]),
        .cap_ctlp  (cap_q[CAP_CTLP_BIT]),
        .gctl      (gctl_q),
        .inprog    (gstat_q[GST_INPROG_BIT]),
        .mce_en    (mce_en),
        .bank_ctl  (bctl_q[inj_idx]),
        .bank_stat (bstat_q[inj_idx]),
        .act       (act),
        .new_status(new_status)
    );

    always_comb begin
        wsel     = reg_sel_e'(wr_sel);
        rsel     = reg_sel_e'(rd_sel);
        bank_idx = wr_en ? wr_bank : inj_idx;
        ctl_we   = wr_en && !init_go && (wsel == SEL_BCTL);
        log_we   = (act == ACT_LOG_UC) || (act == ACT_LOG_CE);
        stat_we  = (wr_en && !init_go && (wsel == SEL_BSTAT)) || log_we || (act == ACT_MARK_OVER);
        stat_d   = wr_en ? wr_data : new_status;
    end

    mca_bank_regs #(.W(W), .NBANK(NBANK)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .init_set(init_go && init_ok),
        .bank_idx(bank_idx),
        .ctl_we  (ctl_we),
        .ctl_d   (wr_data),
        .stat_we (stat_we),
        .stat_d  (stat_d),
        .log_we  (log_we),
        .addr_d  (inj_addr),
        .misc_d  (inj_misc),
        .ctl_q   (bctl_q),
        .stat_q  (bstat_q),
        .addr_q  (baddr_q),
        .misc_q  (bmisc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            gctl_q  <= '0;
            gstat_q <= '0;
            irq_q   <= 1'b0;
            rreq_q  <= 1'b0;
            bcast_q <= 1'b0;
        end else begin
            irq_q  <= (act == ACT_LOG_UC);
            rreq_q <= (act == ACT_RESET);
            if (init_go) begin
                bcast_q <= bcast_c;
                if (init_ok) begin
                    cap_q  <= CAP_INIT;
                    gctl_q <= '1;
                end
            end else if (wr_en) begin
                if (wsel == SEL_GCTL)  gctl_q  <= wr_data;
                if (wsel == SEL_GSTAT) gstat_q <= wr_data;
            end else if (act == ACT_LOG_UC) begin
                gstat_q <= inj_gstat;
            end
        end
    end

    always_comb begin
        case (rsel)
            SEL_CAP:   rd_data = cap_q;
            SEL_GCTL:  rd_data = gctl_q;
            SEL_GSTAT: rd_data = gstat_q;
            SEL_BCTL:  rd_data = bctl_q[rd_bank];
            SEL_BSTAT: rd_data = bstat_q[rd_bank];
            SEL_BADDR: rd_data = baddr_q[rd_bank];
            SEL_BMISC: rd_data = bmisc_q[rd_bank];
            default:   rd_data = '0;
        endcase
    end

    assign mce_irq   = irq_q;
    assign reset_req = rreq_q;
    assign bcast_ok  = bcast_q;
endmodule

// File: rtl/mca_logger_chk.sv
module mca_logger_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         init_go,
    input logic [3:0]   sig_family,
    input logic         feat_mce,
    input logic         feat_mca,
    input logic         inj_vld,
    input logic [W-1:0] inj_status,
    input logic         mce_irq,
    input logic         reset_req,
    input logic [W-1:0] gctl_q
);
    logic init_qual;
    assign init_qual = init_go && (sig_family >= 4'd6) && feat_mce && feat_mca;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mce_irq && reset_req)); // R9

    AST_IRQ_FROM_UC: assert property (@(posedge clk) disable iff (rst)
        mce_irq |-> $past(inj_vld && inj_status[W-3])); // R5

    AST_RESET_FROM_UC: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(inj_vld && inj_status[W-3])); // R4

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && inj_vld && !inj_status[W-1]) |-> (!mce_irq && !reset_req)); // R1

    AST_CE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && inj_vld && !inj_status[W-3]) |-> (!mce_irq && !reset_req)); // R9

    AST_INIT_OPENS_GCTL: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && init_qual) |-> (gctl_q == '1)); // R7
endmodule

bind mca_bank_logger mca_logger_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_go   (init_go),
    .sig_family(sig_family),
    .feat_mce  (feat_mce),
    .feat_mca  (feat_mca),
    .inj_vld   (inj_vld),
    .inj_status(inj_status),
    .mce_irq   (mce_irq),
    .reset_req (reset_req),
    .gctl_q    (gctl_q)
);

// File: tb/tb_mca_bank_logger.sv
module tb_mca_bank_logger;
    localparam int W = 64;
    localparam int NBANK = 4;
    localparam int BW = 2;
    localparam logic [W-1:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [W-1:0] OVER = 64'h4000_0000_0000_0000;
    localparam logic [W-1:0] UC   = 64'h2000_0000_0000_0000;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_go = 0, feat_mce = 0, feat_mca = 0, mce_en = 0;
    logic [3:0] sig_family = 0, sig_model = 0, sig_ext_model = 0;
    logic inj_vld = 0;
    logic [7:0] inj_bank = 0;
    logic [W-1:0] inj_status = 0, inj_gstat = 0, inj_addr = 0, inj_misc = 0;
    logic wr_en = 0;
    logic [2:0] wr_sel = 0, rd_sel = 0;
    logic [BW-1:0] wr_bank = 0, rd_bank = 0;
    logic [W-1:0] wr_data = 0, rd_data;
    logic mce_irq, reset_req, bcast_ok;

    int n_run = 0, n_fail = 0;

    typedef struct { logic irq; logic rrq; string tag; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    mca_bank_logger #(.W(W), .NBANK(NBANK)) dut (
        .clk(clk), .rst(rst), .init_go(init_go), .sig_family(sig_family),
        .sig_model(sig_model), .sig_ext_model(sig_ext_model),
        .feat_mce(feat_mce), .feat_mca(feat_mca), .mce_en(mce_en),
        .inj_vld(inj_vld), .inj_bank(inj_bank), .inj_status(inj_status),
        .inj_gstat(inj_gstat), .inj_addr(inj_addr), .inj_misc(inj_misc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_bank(wr_bank), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_bank(rd_bank), .rd_data(rd_data),
        .mce_irq(mce_irq), .reset_req(reset_req), .bcast_ok(bcast_ok)
    );

    task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, input logic [BW-1:0] bank, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        rd_sel = sel; rd_bank = bank;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [BW-1:0] bank, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_bank = bank; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic init(input logic [3:0] fam, input logic [3:0] ext, input logic [3:0] mdl,
                        input logic mce, input logic mca);
        @(negedge clk);
        init_go = 1; sig_family = fam; sig_ext_model = ext; sig_model = mdl;
        feat_mce = mce; feat_mca = mca;
        @(negedge clk);
        init_go = 0;
    endtask

    task automatic inject(input logic [7:0] bank, input logic [W-1:0] st, input logic [W-1:0] gs,
                          input logic [W-1:0] ad, input logic [W-1:0] mi,
                          input logic e_irq, input logic e_rrq, input string tag);
        exp_t e;
        @(negedge clk);
        inj_vld = 1; inj_bank = bank; inj_status = st; inj_gstat = gs; inj_addr = ad; inj_misc = mi;
        e.irq = e_irq; e.rrq = e_rrq; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        inj_vld = 0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pulses due one cycle after the sampling edge, gone a cycle later
    initial forever begin
        @(posedge clk);
        if (inj_vld && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            #2;
            check(mce_irq === e.irq, {e.tag, " irq"}, W'(mce_irq), W'(e.irq));
            check(reset_req === e.rrq, {e.tag, " reset_req"}, W'(reset_req), W'(e.rrq));
            @(posedge clk);
            #2;
            check(!mce_irq && !reset_req, {e.tag, " R9 pulse width"}, W'({mce_irq, reset_req}), '0);
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R7 reset state
        rd(3'd0, 0, '0, "R7 reset cap");
        rd(3'd1, 0, '0, "R7 reset gctl");
        check(!mce_irq && !reset_req && !bcast_ok, "R7 reset outputs", W'({mce_irq, reset_req, bcast_ok}), '0);

        // R7/R8 non-qualifying inits
        init(4'd5, 4'd0, 4'd0, 1, 1);
        rd(3'd0, 0, '0, "R7 family 5 no init");
        check(bcast_ok === 1'b0, "R8 family 5", W'(bcast_ok), '0);
        init(4'd6, 4'd0, 4'd13, 1, 0);
        rd(3'd0, 0, '0, "R7 missing feature no init");
        check(bcast_ok === 1'b0, "R8 family 6 model 13", W'(bcast_ok), '0);
        init(4'd15, 4'd0, 4'd0, 0, 0);
        check(bcast_ok === 1'b1, "R8 family 15", W'(bcast_ok), 1);
        rd(3'd0, 0, '0, "R7 family 15 no features");
        init(4'd6, 4'd1, 4'd10, 1, 1);
        check(bcast_ok === 1'b1, "R8 extended model 26", W'(bcast_ok), 1);
        rd(3'd0, 0, 64'h104, "R7 cap after init");
        rd(3'd1, 0, ONES, "R7 gctl ones");
        rd(3'd3, 3, ONES, "R7 bank3 ctl ones");

        // R10 capability write ignored
        wr(3'd0, 0, 64'h0);
        rd(3'd0, 0, 64'h104, "R10 cap write ignored");

        mce_en = 1;
        // R1 rejections
        inject(8'd4, VAL | UC | 1, 64'h5, 64'h1, 64'h1, 0, 0, "R1 bank out of range");
        inject(8'd0, UC | 1, 64'h5, 64'h1, 64'h1, 0, 0, "R1 no valid bit");
        rd(3'd4, 0, '0, "R1 bank0 untouched");
        rd(3'd2, 0, '0, "R1 gstat untouched");

        // R5 accepted uncorrected
        inject(8'd0, VAL | UC | 64'h11, 64'h5, 64'hA0, 64'hB0, 1, 0, "R5 uc log");
        rd(3'd4, 0, VAL | UC | 64'h11, "R5 bank0 status");
        rd(3'd2, 0, 64'h5, "R5 gstat");
        rd(3'd5, 0, 64'hA0, "R5 bank0 addr");
        rd(3'd6, 0, 64'hB0, "R5 bank0 misc");

        // R4 reset while in progress
        inject(8'd1, VAL | UC | 64'h12, 64'h1, 64'hA1, 64'hB1, 0, 1, "R4 in progress");
        rd(3'd4, 1, '0, "R4 bank1 not logged");
        wr(3'd2, 0, '0);
        rd(3'd2, 0, '0, "R10 gstat write");
        mce_en = 0;
        inject(8'd1, VAL | UC | 64'h13, 64'h1, 64'hA1, 64'hB1, 0, 1, "R4 enable low");
        mce_en = 1;
        rd(3'd4, 1, '0, "R4 bank1 still empty");

        // R5 overflow on occupied bank
        inject(8'd0, VAL | UC | 64'h22, 64'h1, 64'hA2, 64'hB2, 1, 0, "R5 uc overflow");
        rd(3'd4, 0, VAL | UC | OVER | 64'h22, "R5 overflow set");

        // R6 corrected on uncorrected entry: only overflow
        inject(8'd2, VAL | UC | 64'h44, 64'h1, 64'hA4, 64'hB4, 1, 0, "R5 uc bank2");
        inject(8'd2, VAL | 64'h55, 64'h0, 64'hC2, 64'hD2, 0, 0, "R9 ce on uc");
        rd(3'd4, 2, VAL | UC | OVER | 64'h44, "R6 mark overflow only");
        rd(3'd5, 2, 64'hA4, "R6 addr kept");

        // R6 corrected into empty, then onto corrected
        inject(8'd3, VAL | 64'h66, 64'h7, 64'hC3, 64'hD3, 0, 0, "R9 ce empty");
        rd(3'd4, 3, VAL | 64'h66, "R6 ce logged");
        rd(3'd5, 3, 64'hC3, "R6 ce addr");
        rd(3'd2, 0, 64'h1, "R6 gstat not written by ce");
        inject(8'd3, VAL | 64'h77, 64'h7, 64'hC4, 64'hD4, 0, 0, "R9 ce over ce");
        rd(3'd4, 3, VAL | OVER | 64'h77, "R6 ce overflow");
        rd(3'd6, 3, 64'hD4, "R6 ce misc");

        // R3 bank control drop
        wr(3'd3, 1, 64'h0);
        rd(3'd3, 1, '0, "R10 bank ctl write");
        inject(8'd1, VAL | UC | 64'h81, 64'h1, 64'h1, 64'h1, 0, 0, "R3 bank ctl closed");
        rd(3'd4, 1, '0, "R3 bank1 not logged");

        // R2 global control drop
        wr(3'd1, 0, 64'h0);
        inject(8'd3, VAL | UC | 64'h82, 64'h1, 64'h1, 64'h1, 0, 0, "R2 gctl closed");
        rd(3'd4, 3, VAL | OVER | 64'h77, "R2 bank3 unchanged");
        // corrected still logs with masks closed
        inject(8'd1, VAL | 64'h88, 64'h0, 64'hE1, 64'hF1, 0, 0, "R9 ce masks closed");
        rd(3'd4, 1, VAL | 64'h88, "R6 ce ignores masks");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule